// File: doc/BRIEF.md
# NAND Flash Bus Cycle Controller

This block sits on a simple word-addressed register bus and drives an 8-bit NAND flash device. Software steers the command-latch, address-latch and chip-enable pins by writing a mode register. An access to the data register becomes exactly one timed bus cycle on the flash side. A write drives the low byte of the bus word onto the flash data lines under a write strobe. A read pulses the read strobe and returns the byte it captured.

The strobe length and the data hold time after the strobe come from a packed timing register, counted in clock cycles with fixed offsets added. The block also reports the flash ready/busy pin and its own busy state in a status register. A self-clearing soft reset returns the mode and timing registers to their start-up values. The register bus uses a request/ready handshake. The master holds its request until `bus_ready` is seen high at a rising edge. Accesses that cannot proceed are stalled by keeping `bus_ready` low.

Top module: `nandc_top`

## Requirements
- R1: Register offsets on `bus_addr` are 0x00 data, 0x04 mode, 0x08 status, 0x14 timing and 0x18 soft reset. The mode register keeps only bits 7, 4, 1 and 0, and its other bits read 0. The timing register keeps 8 bits. A read of any other offset returns 0 and completes at once. A write to any other offset is dropped.
- R2: `nand_cle` equals mode bit 0 and `nand_ale` equals mode bit 1, starting in the cycle after the mode write is accepted.
- R3: `nand_ce_n` is low while mode bit 4 is 1 and high while it is 0.
- R4: A data write with mode bit 7, bit 1 or bit 0 set holds `nand_we_n` low for (timing[3:0] + 1) cycles, starting in the cycle after it is accepted. `nand_dq_oe` is high and `nand_dq_out` carries `bus_wdata[7:0]` for the strobe and for the hold phase that follows.
- R5: A data write with mode bits 7, 1 and 0 all clear makes no flash cycle. It completes in the cycle it is presented, and `nand_we_n` stays high.
- R6: A data read holds `nand_re_n` low for (timing[3:0] + 1) cycles with `nand_dq_oe` low. It returns the byte present on `nand_dq_in` during the last strobe cycle, zero-extended to 32 bits.
- R7: After either strobe, a hold phase of (timing[7:4] + 2) cycles follows with both strobes high. `bus_ready` rises in the last hold cycle.
- R8: Status bit 7 reads 1 while `nand_rb_n` is low. Status bit 6 reads 1 while a flash cycle or a soft reset is running.
- R9: Writing 1 to bit 0 of the reset register starts a soft reset. That bit reads 1 for the 4 cycles after the write. When it clears, mode is 0 and timing is 0xFF. Writing 0 there has no effect.
- R10: While a flash cycle or soft reset runs, every access except reads of status and of the reset register is stalled. A stalled write takes effect only after the running operation ends.
- R11: After `rst`, mode is 0, timing is 0xFF, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, and `nand_cle`, `nand_ale` and `nand_dq_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | Access completes at this edge |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data to the flash |
| nand_dq_oe | output | 1 | Drive enable for nand_dq_out |
| nand_dq_in | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
Two functions can land in the same cycle: a soft reset finishing, and a mode write that was stalled behind it. The bench starts a soft reset and polls the reset bit and the status register during the window. It then issues a mode write straight away. The write must be held off and must survive the reset's clearing of the mode register, so it is judged by the pin levels in every cycle and by a read-back of 0x11. A behavioural model that counts strobe and hold cycles is also compared on every clock against all flash pins and against ready. This covers data cycles that end exactly as the next request arrives.

// File: rtl/nandc_pkg.sv
package nandc_pkg;

    localparam int ADDR_W   = 8;
    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int TFIELD_W = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TIME = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SRST = 8'h18;

    localparam logic [BYTE_W-1:0] MODE_KEEP = 8'h93;
    localparam logic [BYTE_W-1:0] TIME_INIT = 8'hFF;

    localparam int SB_CTRL  = 6;
    localparam int SB_FLASH = 7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_MODE,
        SEL_STAT,
        SEL_TIME,
        SEL_SRST
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // bit layout matches the software view of the timing word
    typedef struct packed {
        logic [TFIELD_W-1:0] hold;
        logic [TFIELD_W-1:0] strobe;
    } timing_t;

    // bit layout matches the software view of the mode word
    typedef struct packed {
        logic       dout_en;
        logic [1:0] rsv_hi;
        logic       ce;
        logic [1:0] rsv_lo;
        logic       ale;
        logic       cle;
    } mode_t;

    typedef struct packed {
        logic              go;
        logic              is_write;
        logic [BYTE_W-1:0] wbyte;
    } seq_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_DATA: s = SEL_DATA;
            OFS_MODE: s = SEL_MODE;
            OFS_STAT: s = SEL_STAT;
            OFS_TIME: s = SEL_TIME;
            OFS_SRST: s = SEL_SRST;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // reads always make a flash cycle; writes need a latch or output enable
    function automatic logic cycle_allowed(input mode_t m, input logic is_write);
        return !is_write || m.dout_en || m.cle || m.ale;
    endfunction

endpackage

// File: rtl/nandc_regs.sv
module nandc_regs
    import nandc_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic              time_we,
    input  logic              srst_we,
    input  logic [BYTE_W-1:0] wbyte,
    output mode_t             mode_q,
    output timing_t           time_q,
    output logic              srst_busy
);

    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic [RC_W-1:0] rst_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            time_q  <= timing_t'(TIME_INIT);
            rst_cnt <= '0;
        end else if (rst_cnt != '0) begin
            rst_cnt <= rst_cnt - RC_W'(1);
            if (rst_cnt == RC_W'(1)) begin
                mode_q <= '0;
                time_q <= timing_t'(TIME_INIT);
            end
        end else begin
            if (mode_we) mode_q <= mode_t'(wbyte & MODE_KEEP);
            if (time_we) time_q <= timing_t'(wbyte);
            if (srst_we && wbyte[0]) rst_cnt <= RC_W'(RST_CYCLES);
        end
    end

    assign srst_busy = (rst_cnt != '0);

    // R9: a finished soft reset leaves mode cleared and timing at maximum
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(srst_busy) |-> (mode_q == '0 && time_q == timing_t'(TIME_INIT)));

    // R9: the reset window is longer than a single cycle
    a_r9_reset_window: assert property (@(posedge clk) disable iff (rst)
        $rose(srst_busy) |=> srst_busy);

endmodule

// File: rtl/nandc_seq.sv
module nandc_seq
    import nandc_pkg::*;
#(
    parameter int TW = TFIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_cmd_t          cmd,
    input  logic [TW-1:0]     strobe_len,
    input  logic [TW-1:0]     hold_len,
    input  logic [BYTE_W-1:0] dq_in,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [BYTE_W-1:0] rbyte,
    output logic              active,
    output logic              done
);

    localparam int CW = TW + 1;

    phase_e            phase;
    logic [CW-1:0]     cnt;
    logic              dir_wr;
    logic [BYTE_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            dir_wr <= 1'b0;
            out_q  <= '0;
            rbyte  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (cmd.go) begin
                        phase  <= PH_STROBE;
                        cnt    <= CW'(strobe_len);
                        dir_wr <= cmd.is_write;
                        out_q  <= cmd.wbyte;
                    end
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        if (!dir_wr) rbyte <= dq_in;
                        phase <= PH_HOLD;
                        cnt   <= CW'(hold_len) + CW'(1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - CW'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign we_n   = !(phase == PH_STROBE && dir_wr);
    assign re_n   = !(phase == PH_STROBE && !dir_wr);
    assign dq_oe  = (phase != PH_IDLE) && dir_wr;
    assign dq_out = out_q;
    assign active = (phase != PH_IDLE);
    assign done   = (phase == PH_HOLD) && (cnt == '0);

    // R4: never both strobes at once
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~we_n, ~re_n}));

    // R6: bus released while the flash drives it
    a_r6_bus_released: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !dq_oe);

    // R4: write data steady for the whole driven window
    a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    // R7: completion falls in the hold phase, never under a strobe
    a_r7_done_in_hold: assert property (@(posedge clk) disable iff (rst)
        done |-> (we_n && re_n));

endmodule

// File: rtl/nandc_top.sv
module nandc_top
    import nandc_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ready,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [BYTE_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [BYTE_W-1:0] nand_dq_in,
    input  logic              nand_rb_n
);

    reg_sel_e          sel;
    mode_t             mode_q;
    timing_t           time_q;
    logic              srst_busy;
    logic              seq_active;
    logic              seq_done;
    logic [BYTE_W-1:0] rbyte;
    logic              ctrl_busy;
    logic              free_read;
    logic              data_go;
    logic              wr_ok;
    seq_cmd_t          cmd;

    assign sel       = decode_addr(bus_addr);
    assign ctrl_busy = seq_active || srst_busy;
    assign free_read = !bus_wr && (sel == SEL_STAT || sel == SEL_SRST);
    assign data_go   = (sel == SEL_DATA) && cycle_allowed(mode_q, bus_wr);
    assign wr_ok     = bus_req && bus_wr && !ctrl_busy;

    assign cmd.go       = bus_req && data_go && !ctrl_busy;
    assign cmd.is_write = bus_wr;
    assign cmd.wbyte    = bus_wdata[BYTE_W-1:0];

    nandc_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .mode_we   (wr_ok && sel == SEL_MODE),
        .time_we   (wr_ok && sel == SEL_TIME),
        .srst_we   (wr_ok && sel == SEL_SRST),
        .wbyte     (bus_wdata[BYTE_W-1:0]),
        .mode_q    (mode_q),
        .time_q    (time_q),
        .srst_busy (srst_busy)
    );

    nandc_seq #(.TW(TFIELD_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .strobe_len (time_q.strobe),
        .hold_len   (time_q.hold),
        .dq_in      (nand_dq_in),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .dq_out     (nand_dq_out),
        .dq_oe      (nand_dq_oe),
        .rbyte      (rbyte),
        .active     (seq_active),
        .done       (seq_done)
    );

    always_comb begin
        if (!bus_req)                        bus_ready = 1'b0;
        else if (free_read)                  bus_ready = 1'b1;
        else if (sel == SEL_DATA && seq_active) bus_ready = seq_done;
        else if (ctrl_busy)                  bus_ready = 1'b0;
        else                                 bus_ready = !data_go;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA: bus_rdata[BYTE_W-1:0] = rbyte;
            SEL_MODE: bus_rdata[BYTE_W-1:0] = mode_q;
            SEL_STAT: begin
                bus_rdata[SB_FLASH] = !nand_rb_n;
                bus_rdata[SB_CTRL]  = ctrl_busy;
            end
            SEL_TIME: bus_rdata[BYTE_W-1:0] = time_q;
            SEL_SRST: bus_rdata[0] = srst_busy;
            default:  bus_rdata = '0;
        endcase
    end

    assign nand_cle  = mode_q.cle;
    assign nand_ale  = mode_q.ale;
    assign nand_ce_n = !mode_q.ce;

    // R10: stalled accesses never complete while an operation is running
    a_r10_stall: assert property (@(posedge clk) disable iff (rst)
        (bus_req && srst_busy && !free_read) |-> !bus_ready);

    // R10: a new flash cycle never starts on top of a soft reset
    a_r10_no_cycle_in_reset: assert property (@(posedge clk) disable iff (rst)
        srst_busy |=> (nand_we_n && nand_re_n));

endmodule

// File: tb/test_nandc_top.sv
`timescale 1ns/1ps
module test_nandc_top;
    import nandc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  dq_in = '0;
    logic        rb_n = 1'b1;

    logic [31:0] bus_rdata;
    logic        bus_ready, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;

    nandc_top i_nandc_top (
        .clk(clk), .rst(rst), .bus_req(req), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(dq_in), .nand_rb_n(rb_n)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    logic [7:0] m_mode = 8'h00;
    logic [7:0] m_tim  = 8'hFF;
    logic [7:0] m_byte = 8'h00;
    logic [7:0] m_rbyte = 8'h00;
    int m_st = 0, m_hd = 0, m_rst = 0;
    bit m_dir = 0;
    int cyc = 0;
    int we_lows = 0;

    function automatic bit m_busy();
        return (m_st > 0) || (m_hd > 0) || (m_rst > 0);
    endfunction

    function automatic bit m_go();
        return !wr || m_mode[7] || m_mode[1] || m_mode[0];
    endfunction

    function automatic bit m_ready();
        if (!req) return 0;
        if (!wr && (addr == 8'h08 || addr == 8'h18)) return 1;
        if (addr == 8'h00 && (m_st > 0 || m_hd > 0)) return (m_st == 0 && m_hd == 1);
        if (m_busy()) return 0;
        if (addr == 8'h00 && m_go()) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] m_rdata();
        case (addr)
            8'h00: return {24'h0, m_rbyte};
            8'h04: return {24'h0, m_mode};
            8'h08: return {24'h0, ~rb_n, m_busy(), 6'h0};
            8'h14: return {24'h0, m_tim};
            8'h18: return {31'h0, (m_rst > 0)};
            default: return 32'h0;
        endcase
    endfunction

    // flash side stimulus: data lines change every cycle
    always @(negedge clk) begin
        cyc++;
        dq_in = 8'(cyc * 37 + 11);
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            bit exp_rdy;
            if (!nand_we_n) we_lows++;
            chk(nand_cle == m_mode[0], "R2 cle", 32'(nand_cle), 32'(m_mode[0]));
            chk(nand_ale == m_mode[1], "R2 ale", 32'(nand_ale), 32'(m_mode[1]));
            chk(nand_ce_n == !m_mode[4], "R3 ce_n", 32'(nand_ce_n), 32'(!m_mode[4]));
            chk(nand_we_n == !(m_st > 0 && m_dir), "R4 we_n", 32'(nand_we_n), 32'(!(m_st > 0 && m_dir)));
            chk(nand_re_n == !(m_st > 0 && !m_dir), "R6 re_n", 32'(nand_re_n), 32'(!(m_st > 0 && !m_dir)));
            chk(nand_dq_oe == ((m_st > 0 || m_hd > 0) && m_dir), "R4 dq_oe",
                32'(nand_dq_oe), 32'((m_st > 0 || m_hd > 0) && m_dir));
            if (nand_dq_oe) chk(nand_dq_out == m_byte, "R4 dq_out", 32'(nand_dq_out), 32'(m_byte));
            exp_rdy = m_ready();
            chk(bus_ready == exp_rdy, "R7 R10 ready", 32'(bus_ready), 32'(exp_rdy));
            if (exp_rdy && !wr) chk(bus_rdata == m_rdata(), "R1 rdata", bus_rdata, m_rdata());
        end
    end

    // model update at the clock edge
    always @(posedge clk) begin
        if (rst) begin
            m_mode = 8'h00; m_tim = 8'hFF; m_st = 0; m_hd = 0; m_rst = 0; m_rbyte = 8'h00;
        end else begin
            bit busy_pre;
            busy_pre = m_busy();
            if (m_st > 0) begin
                if (!m_dir && m_st == 1) m_rbyte = dq_in;
                m_st--;
            end else if (m_hd > 0) begin
                m_hd--;
            end
            if (m_rst > 0) begin
                m_rst--;
                if (m_rst == 0) begin m_mode = 8'h00; m_tim = 8'hFF; end
            end else if (!busy_pre && req) begin
                if (addr == 8'h00 && m_go()) begin
                    m_st = int'(m_tim[3:0]) + 1;
                    m_hd = int'(m_tim[7:4]) + 2;
                    m_dir = wr;
                    m_byte = wdata[7:0];
                end else if (wr) begin
                    case (addr)
                        8'h04: m_mode = wdata[7:0] & 8'h93;
                        8'h14: m_tim = wdata[7:0];
                        8'h18: if (wdata[0]) m_rst = 4;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic acc(input bit w, input logic [7:0] a, input logic [31:0] d, output logic [31:0] r);
        bit got;
        got = 0;
        r = '0;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        while (!got) begin
            #1;
            if (bus_ready) begin
                r = bus_rdata;
                got = 1;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] r;
        int w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(nand_ce_n && nand_we_n && nand_re_n, "R11 strobes and ce high",
            {29'h0, nand_ce_n, nand_we_n, nand_re_n}, 32'h7);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R11 latches and oe low",
            {29'h0, nand_cle, nand_ale, nand_dq_oe}, 32'h0);
        acc(0, 8'h04, 0, r); chk(r == 32'h0, "R11 mode", r, 32'h0);
        acc(0, 8'h14, 0, r); chk(r == 32'hFF, "R11 timing", r, 32'hFF);

        // R1 register map and masking
        acc(1, 8'h14, 32'h0000_0021, r);
        acc(0, 8'h14, 0, r); chk(r == 32'h21, "R1 timing readback", r, 32'h21);
        acc(1, 8'h04, 32'hFFFF_FFFF, r);
        acc(0, 8'h04, 0, r); chk(r == 32'h93, "R1 mode mask", r, 32'h93);
        acc(0, 8'h0C, 0, r); chk(r == 32'h0, "R1 unmapped", r, 32'h0);

        // R2 R3 command byte with CLE and CE
        acc(1, 8'h04, 32'h11, r);
        w0 = we_lows;
        acc(1, 8'h00, 32'h0000_0070, r);
        chk(we_lows - w0 == 2, "R4 strobe length", 32'(we_lows - w0), 32'd2);

        // address byte with ALE
        acc(1, 8'h04, 32'h12, r);
        acc(1, 8'h00, 32'h0000_0005, r);

        // R5 plain data write without output enable is dropped
        acc(1, 8'h04, 32'h10, r);
        w0 = we_lows;
        acc(1, 8'h00, 32'h0000_00AA, r);
        chk(we_lows == w0, "R5 no strobe", 32'(we_lows - w0), 32'd0);

        // data writes with output enable, two timings
        acc(1, 8'h04, 32'h90, r);
        acc(1, 8'h00, 32'h0000_005C, r);
        acc(1, 8'h14, 32'hF3, r);
        w0 = we_lows;
        acc(1, 8'h00, 32'hDEAD_BEC3, r);
        chk(we_lows - w0 == 4, "R4 long strobe", 32'(we_lows - w0), 32'd4);

        // R6 reads under several timings
        acc(1, 8'h14, 32'h14, r);
        acc(0, 8'h00, 0, r); chk(r[31:8] == 24'h0, "R6 zero extend", r, {24'h0, r[7:0]});
        acc(1, 8'h14, 32'h01, r);
        acc(0, 8'h00, 0, r);
        acc(1, 8'h14, 32'h30, r);
        acc(0, 8'h00, 0, r);

        // R8 status
        rb_n = 1'b0;
        acc(0, 8'h08, 0, r); chk(r == 32'h80, "R8 flash busy", r, 32'h80);
        rb_n = 1'b1;
        acc(0, 8'h08, 0, r); chk(r == 32'h00, "R8 flash ready", r, 32'h00);

        // R9 writing zero to reset does nothing
        acc(1, 8'h18, 32'h0, r);
        acc(0, 8'h18, 0, r); chk(r == 32'h0, "R9 zero write", r, 32'h0);
        acc(0, 8'h14, 0, r); chk(r == 32'h30, "R9 timing kept", r, 32'h30);

        // R9 R10 soft reset with a stalled mode write behind it
        acc(1, 8'h18, 32'h1, r);
        acc(0, 8'h18, 0, r); chk(r == 32'h1, "R9 reset bit set", r, 32'h1);
        acc(1, 8'h04, 32'h11, r);
        acc(0, 8'h04, 0, r); chk(r == 32'h11, "R10 stalled write kept", r, 32'h11);
        acc(0, 8'h14, 0, r); chk(r == 32'hFF, "R9 timing restored", r, 32'hFF);
        acc(0, 8'h18, 0, r); chk(r == 32'h0, "R9 reset bit cleared", r, 32'h0);

        // R8 controller busy seen during reset
        acc(1, 8'h18, 32'h1, r);
        acc(0, 8'h08, 0, r); chk(r == 32'h40, "R8 ctrl busy", r, 32'h40);
        repeat (8) @(negedge clk);

        summary();
    end

endmodule